// File: doc/BRIEF.md
# Mono/Stereo Channel Converter

This block sits in a streaming audio path, between a client-side sample interface and a serial audio port, and changes how many channels each sample frame carries. Samples arrive one per beat on a valid/ready handshake. A marker flags the beat that carries the first channel of a frame. Converted samples leave on a handshake of the same shape. A playback path and a capture path each use their own instance, so each direction has its own settings.

A two-bit mode selects one of three behaviours. In pass mode, frames go through untouched. In stereo-to-mono mode, each left/right pair becomes one output sample: channel 0 kept, channel 1 kept, or the floor average of the two. In mono-to-stereo mode, each sample becomes a pair: the second channel is either zero or a copy of the sample. Settings are sampled only between frames, so no pair is ever split across two settings. The sample width is a static parameter: 8, 16 or 32 bits, two's complement.

Top module: `chan_conv`

## Requirements
- R1: With mode 0 (and also mode 3), every input beat is forwarded with its data and frame marker unchanged.
- R2: With mode 1, a beat with the marker set is held as channel 0. The next beat without the marker completes the pair and yields one output beat with the marker set. That beat carries channel 0 for reduce setting 0 (or 3), and channel 1 for reduce setting 1.
- R3: With mode 1 and reduce setting 2, the output is the sum of both channels, formed one bit wider, arithmetically shifted right by one (rounded toward negative infinity).
- R4: With mode 2, each input beat yields two output beats. The first carries the sample with the marker set. The second has the marker clear and carries zero for fill setting 0, or the sample again for fill setting 1.
- R5: Mode, reduce and fill settings are taken only when no half pair is held and no generated beat is pending. A change during a frame affects only later frames.
- R6: While out_valid is high and out_ready is low, out_data and out_first hold their values, and no beat is lost.
- R7: While a generated second beat is waiting to be emitted, in_ready is low.
- R8: In mode 1, a beat without the marker that arrives while no channel 0 is held is discarded. A marked beat that arrives while channel 0 is held replaces it.
- R9: Reset clears any held or pending sample: out_valid is low and in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 pass, 1 stereo-to-mono, 2 mono-to-stereo, 3 pass |
| cfg_reduce | input | 2 | Stereo-to-mono reduction: 0 channel 0, 1 channel 1, 2 average, 3 channel 0 |
| cfg_fill | input | 1 | Mono-to-stereo second channel: 0 zero, 1 copy |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | SAMPLE_W | Signed input sample |
| in_first | input | 1 | Input beat is the first channel of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | SAMPLE_W | Signed output sample |
| out_first | output | 1 | Output beat is the first channel of a frame |

## Verification
In mono-to-stereo mode, three things can land on the same edge: downstream frees the output slot, the pending generated beat moves into that slot, and a new sample waits at the input. The bench stalls the output while the pending beat exists, flips the fill setting, and then releases the stall. Pass is judged by in_ready staying low through the stall, by the pending beat coming out second with its marker clear, and by that beat keeping the fill value taken before the change. A second overlap, a setting change landing between the two beats of a stereo pair, is judged by the reduced output still following the old setting.

// File: rtl/chan_conv.sv
module chan_conv #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_reduce,
  input  logic                cfg_fill,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_first,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_first
);
  localparam logic [1:0] MODE_S2M = 2'd1;
  localparam logic [1:0] MODE_M2S = 2'd2;

  logic [1:0]          mode_q, red_q;
  logic                fill_q;
  logic                have_half, dup_pending;
  logic [SAMPLE_W-1:0] half_q, dup_q, out_q;
  logic                out_v, out_f;

  logic                at_edge, slot_free, in_fire, fill_e;
  logic [1:0]          mode_e, red_e;
  logic signed [SAMPLE_W:0] sum_w;
  logic [SAMPLE_W-1:0] reduced;

  assign at_edge   = !have_half && !dup_pending;
  assign mode_e    = at_edge ? cfg_mode   : mode_q;
  assign red_e     = at_edge ? cfg_reduce : red_q;
  assign fill_e    = at_edge ? cfg_fill   : fill_q;

  assign slot_free = !out_v || out_ready;
  assign in_ready  = slot_free && !dup_pending;
  assign in_fire   = in_valid && in_ready;

  assign sum_w = $signed({half_q[SAMPLE_W-1], half_q}) + $signed({in_data[SAMPLE_W-1], in_data});

  always_comb begin
    case (red_e)
      2'd1:    reduced = in_data;
      2'd2:    reduced = sum_w[SAMPLE_W:1];
      default: reduced = half_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      red_q       <= '0;
      fill_q      <= 1'b0;
      have_half   <= 1'b0;
      dup_pending <= 1'b0;
      half_q      <= '0;
      dup_q       <= '0;
      out_q       <= '0;
      out_v       <= 1'b0;
      out_f       <= 1'b0;
    end else begin
      if (at_edge) begin
        mode_q <= cfg_mode;
        red_q  <= cfg_reduce;
        fill_q <= cfg_fill;
      end
      if (slot_free) begin
        if (dup_pending) begin
          out_q       <= dup_q;
          out_f       <= 1'b0;
          out_v       <= 1'b1;
          dup_pending <= 1'b0;
        end else if (in_fire) begin
          case (mode_e)
            MODE_S2M: begin
              if (in_first) begin
                half_q    <= in_data;
                have_half <= 1'b1;
                out_v     <= 1'b0;
              end else if (have_half) begin
                out_q     <= reduced;
                out_f     <= 1'b1;
                out_v     <= 1'b1;
                have_half <= 1'b0;
              end else begin
                out_v     <= 1'b0;
              end
            end
            MODE_M2S: begin
              out_q       <= in_data;
              out_f       <= 1'b1;
              out_v       <= 1'b1;
              dup_pending <= 1'b1;
              dup_q       <= fill_e ? in_data : '0;
            end
            default: begin
              out_q <= in_data;
              out_f <= in_first;
              out_v <= 1'b1;
            end
          endcase
        end else begin
          out_v <= 1'b0;
        end
      end
    end
  end

  assign out_valid = out_v;
  assign out_data  = out_q;
  assign out_first = out_f;
endmodule

// File: rtl/chan_conv_chk.sv
module chan_conv_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_first,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_first,
  input logic         have_half,
  input logic         dup_pending
);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first));

  a_r7_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    dup_pending |-> !in_ready);

  a_r4_tail_marker: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && dup_pending |=> out_valid && !out_first);

  a_r2_mono_marker: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && have_half && !in_first |=> out_valid && out_first);

  a_r8_one_partial: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({have_half, dup_pending}));
endmodule

bind chan_conv chan_conv_chk #(.W(SAMPLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_first(in_first), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_first(out_first),
  .have_half(have_half), .dup_pending(dup_pending)
);

// File: tb/chan_conv_tb.sv
module chan_conv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // mode, reduce, fill, a, b, expected count, e0, e1
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 16'h1234, 16'hABCD, 2'd2, 16'h1234, 16'hABCD},
    {2'd3, 2'd0, 1'b0, 16'h0001, 16'hFFFF, 2'd2, 16'h0001, 16'hFFFF},
    {2'd1, 2'd0, 1'b0, 16'h1111, 16'h2222, 2'd1, 16'h1111, 16'h0000},
    {2'd1, 2'd1, 1'b0, 16'h1111, 16'h2222, 2'd1, 16'h2222, 16'h0000},
    {2'd1, 2'd3, 1'b0, 16'h5555, 16'hAAAA, 2'd1, 16'h5555, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'h0004, 16'h0008, 2'd1, 16'h0006, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'hFFFD, 16'h0000, 2'd1, 16'hFFFE, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'h0003, 16'h0000, 2'd1, 16'h0001, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'h7FFF, 16'h7FFF, 2'd1, 16'h7FFF, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'h8000, 16'h8000, 2'd1, 16'h8000, 16'h0000},
    {2'd1, 2'd2, 1'b0, 16'h7FFF, 16'h8000, 2'd1, 16'hFFFF, 16'h0000},
    {2'd2, 2'd0, 1'b0, 16'h8001, 16'h0000, 2'd2, 16'h8001, 16'h0000},
    {2'd2, 2'd0, 1'b1, 16'h8001, 16'h0000, 2'd2, 16'h8001, 16'h8001},
    {2'd2, 2'd0, 1'b1, 16'h7FFE, 16'h0000, 2'd2, 16'h7FFE, 16'h7FFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_reduce = 2'd0;
  logic        cfg_fill = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_first = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_first;

  int total = 0;
  int bad = 0;
  logic [16:0] got[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_conv #(.SAMPLE_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_reduce(cfg_reduce),
    .cfg_fill(cfg_fill), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_first(out_first)
  );

  always begin
    @(negedge clk);
    #2;
    if (out_valid && out_ready) got.push_back({out_first, out_data});
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic f, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_first = f;
    in_data  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset out_valid", 32'(out_valid), 32'd0);
    check("R9 reset in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      cfg_mode   = v[70:69];
      cfg_reduce = v[68:67];
      cfg_fill   = v[66];
      got.delete();
      if (v[70:69] == 2'd1) tag = (v[68:67] == 2'd2) ? "R3" : "R2";
      else if (v[70:69] == 2'd2) tag = "R4";
      else tag = "R1";
      send(1'b1, v[65:50]);
      if (v[70:69] != 2'd2) send(1'b0, v[49:34]);
      settle();
      check(tag, 32'(got.size()), 32'(v[33:32]));
      for (int k = 0; k < int'(v[33:32]); k++) begin
        if (k < got.size()) begin
          check(tag, 32'(got[k][15:0]), 32'((k == 0) ? v[31:16] : v[15:0]));
          check(tag, 32'(got[k][16]), 32'((k == 0) ? 1 : 0));
        end
      end
    end

    // R6 R7 R5: stall with a pending generated beat, fill flipped meanwhile
    @(negedge clk);
    got.delete();
    out_ready  = 1'b0;
    cfg_mode   = 2'd2;
    cfg_fill   = 1'b0;
    in_valid   = 1'b1;
    in_first   = 1'b1;
    in_data    = 16'h0BAD;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_fill = 1'b1;
    #1;
    check("R6 held valid", 32'(out_valid), 32'd1);
    check("R7 input blocked", 32'(in_ready), 32'd0);
    repeat (2) begin
      @(negedge clk);
      #1;
      check("R6 held data", 32'(out_data), 32'h0BAD);
      check("R6 held marker", 32'(out_first), 32'd1);
      check("R7 input blocked", 32'(in_ready), 32'd0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    settle();
    check("R6 no loss", 32'(got.size()), 32'd2);
    if (got.size() == 2) begin
      check("R6 first beat", 32'(got[0]), 32'({1'b1, 16'h0BAD}));
      check("R5 old fill kept", 32'(got[1]), 32'({1'b0, 16'h0000}));
    end

    // R5: setting change between the two beats of a stereo pair
    @(negedge clk);
    got.delete();
    cfg_mode = 2'd1;
    cfg_reduce = 2'd0;
    send(1'b1, 16'h0101);
    cfg_mode = 2'd0;
    cfg_reduce = 2'd1;
    send(1'b0, 16'h0202);
    settle();
    check("R5 pair count", 32'(got.size()), 32'd1);
    if (got.size() == 1) check("R5 pair kept old", 32'(got[0]), 32'({1'b1, 16'h0101}));
    got.delete();
    send(1'b1, 16'h0303);
    send(1'b0, 16'h0404);
    settle();
    check("R5 new setting count", 32'(got.size()), 32'd2);
    if (got.size() == 2) check("R5 new setting data", 32'(got[1]), 32'({1'b0, 16'h0404}));

    // R8: orphan second beat dropped, repeated marked beat replaces
    @(negedge clk);
    got.delete();
    cfg_mode = 2'd1;
    cfg_reduce = 2'd0;
    send(1'b0, 16'h7777);
    settle();
    check("R8 orphan dropped", 32'(got.size()), 32'd0);
    send(1'b1, 16'h1000);
    send(1'b1, 16'h2000);
    send(1'b0, 16'h3000);
    settle();
    check("R8 replace count", 32'(got.size()), 32'd1);
    if (got.size() == 1) check("R8 replaced ch0", 32'(got[0]), 32'({1'b1, 16'h2000}));

    // R9: reset during a half-held pair clears it
    got.delete();
    send(1'b1, 16'h4444);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R9 mid reset out_valid", 32'(out_valid), 32'd0);
    check("R9 mid reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    send(1'b0, 16'h5555);
    settle();
    check("R9 half cleared", 32'(got.size()), 32'd0);
    send(1'b1, 16'h6666);
    send(1'b0, 16'h7777);
    settle();
    check("R2 after reset", 32'(got.size()), 32'd1);
    if (got.size() == 1) check("R2 after reset data", 32'(got[0]), 32'({1'b1, 16'h6666}));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule